// File: doc/BRIEF.md
# Relocatable Power-Management I/O Window Decoder

This block places a 64-byte power-management register window anywhere in a 16-bit host I/O space and decides, access by access, whether the window claims it. Software programs a 32-bit base register and an enable byte through configuration writes. The base it writes does not move the window by itself. The window is rebuilt only when the enable byte is written. At that point the block takes the current base, masked to 16 bits with bit 0 cleared, and the enable bit.

On the host side the block looks at each I/O access: a valid strobe, a 16-bit address and a size code. It raises a hit flag, with the 6-bit offset into the window, when three things are true. The window is on. The address falls in the window's 64-byte-aligned block. The access is 2 or 4 bytes wide and ends inside the window. Byte accesses are never claimed, so byte-wide devices that share the range keep working.

Top module: `pm_window_decoder`

## Requirements
- R1: After reset, the base register (config dword index 0x10, i.e. byte offset 0x40) reads 0x00000001, the enable register (dword index 0x20, byte offset 0x80) reads 0x00000000, and no I/O access hits.
- R2: A write to the base dword updates each byte whose `cfg_be` bit is set. Bit 0 always reads back as 1. Every other bit reads back as written.
- R3: Byte lane 0 of the enable dword holds 8 read/write bits, and the upper three bytes of that dword read 0. Any other dword index reads 0, and writes to it change no readable register and no window.
- R4: A base write alone never moves, enables or disables the window. A write to the enable dword with `cfg_be[0]` set latches the base held at that moment and enable bit 0. The new window decodes from the cycle after the clock edge that takes the write.
- R5: An enable write with data bit 0 clear turns the window off from the next cycle, and no access hits while it is off.
- R6: While the window is on, an access hits when `io_valid` is 1, `io_addr[15:6]` equals latched base bits [15:6], and `io_size` is 1 (2 bytes) or 2 (4 bytes). `io_offset` is then `io_addr[5:0]`, and it is 0 whenever there is no hit.
- R7: `io_size` 0 (1 byte) and 3 (reserved) never hit.
- R8: An access whose last byte would lie past the window end (offset + bytes > 64) does not hit.
- R9: With `io_valid` low, `io_hit` is 0.
- R10: Base bits [5:1] and [31:16] do not affect where the window sits. The window starts at base & 0xFFC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration dword index for reads and writes |
| cfg_be | input | 4 | Byte enables for a configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data at `cfg_addr` (combinational) |
| io_valid | input | 1 | Host I/O access present |
| io_addr | input | 16 | Host I/O byte address |
| io_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| io_hit | output | 1 | Access claimed by the window |
| io_offset | output | 6 | Offset within the window when hit, else 0 |

## Verification
The assertions assume that the configuration inputs are stable across a clock edge and that every configuration write addresses one dword. They also assume that the host side presents a fresh address and size each cycle, with no protocol around them. The stimulus drives configuration writes at the falling edge and releases them one cycle later. It sweeps host addresses and all four size codes across the neighbourhood of each window with no configuration write in flight, so the combinational decode is always judged against a settled window.

// File: rtl/pm_window_decoder.sv
module pm_window_decoder #(
  parameter int IO_AW     = 16,
  parameter int WIN_LOG2  = 6,
  parameter int CFG_IDX_W = 6,
  parameter int BASE_IDX  = 16,
  parameter int EN_IDX    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_IDX_W-1:0] cfg_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 io_valid,
  input  logic [IO_AW-1:0]     io_addr,
  input  logic [1:0]           io_size,
  output logic                 io_hit,
  output logic [WIN_LOG2-1:0]  io_offset
);

  localparam int TAG_W     = IO_AW - WIN_LOG2;
  localparam int WIN_BYTES = 1 << WIN_LOG2;
  localparam logic [CFG_IDX_W-1:0] BASE_SEL = CFG_IDX_W'(BASE_IDX);
  localparam logic [CFG_IDX_W-1:0] EN_SEL   = CFG_IDX_W'(EN_IDX);

  logic [31:0]      base_q;
  logic [7:0]       en_q;
  logic [TAG_W-1:0] win_tag_q;
  logic             win_on_q;

  wire base_wr = cfg_wr && (cfg_addr == BASE_SEL);
  wire en_wr   = cfg_wr && (cfg_addr == EN_SEL) && cfg_be[0];
  wire [IO_AW-1:0] base_eff = {base_q[IO_AW-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= 32'h1;
    end else if (base_wr) begin
      for (int b = 0; b < 4; b++)
        if (cfg_be[b]) base_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
      base_q[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      win_on_q  <= 1'b0;
      win_tag_q <= '0;
    end else if (en_wr) begin
      en_q      <= cfg_wdata[7:0];
      win_on_q  <= cfg_wdata[0];
      win_tag_q <= base_eff[IO_AW-1:WIN_LOG2];
    end
  end

  always_comb begin
    if (cfg_addr == BASE_SEL)    cfg_rdata = base_q;
    else if (cfg_addr == EN_SEL) cfg_rdata = {24'h0, en_q};
    else                         cfg_rdata = '0;
  end

  logic [2:0] nbytes;
  always_comb begin
    case (io_size)
      2'd1:    nbytes = 3'd2;
      2'd2:    nbytes = 3'd4;
      default: nbytes = 3'd0;
    endcase
  end

  wire [WIN_LOG2:0] end_pos = {1'b0, io_addr[WIN_LOG2-1:0]} + (WIN_LOG2+1)'(nbytes);
  wire fits    = end_pos <= (WIN_LOG2+1)'(WIN_BYTES);
  wire tag_eq  = io_addr[IO_AW-1:WIN_LOG2] == win_tag_q;

  assign io_hit    = io_valid && win_on_q && tag_eq && (nbytes != 3'd0) && fits;
  assign io_offset = io_hit ? io_addr[WIN_LOG2-1:0] : '0;

  AST_BASE_BIT0_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == BASE_SEL) |-> cfg_rdata[0]); // R2
  AST_BASE_WR_HOLDS_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> ($stable(win_tag_q) && $stable(win_on_q))); // R4
  AST_OFF_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !cfg_wdata[0]) |=> !io_hit); // R5
  AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (io_offset == io_addr[WIN_LOG2-1:0])); // R6
  AST_NO_BYTE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (io_size == 2'd0 || io_size == 2'd3) |-> !io_hit); // R7
  AST_DWORD_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (io_hit && io_size == 2'd2) |-> (int'(io_addr[WIN_LOG2-1:0]) <= WIN_BYTES - 4)); // R8
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !io_valid |-> !io_hit); // R9

endmodule

// File: tb/pm_window_decoder_tb_top.sv
`timescale 1ns/1ps
module pm_window_decoder_tb_top;
  logic clk = 0, rst_n = 0;
  logic cfg_wr = 0;
  logic [5:0] cfg_addr = 0;
  logic [3:0] cfg_be = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic io_valid = 0;
  logic [15:0] io_addr = 0;
  logic [1:0] io_size = 0;
  logic io_hit;
  logic [5:0] io_offset;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] base_m = 32'h1;
  logic [7:0]  en_m = 0;
  logic [9:0]  wtag_m = 0;
  bit          won_m = 0;

  pm_window_decoder dut_i (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .io_valid(io_valid),
    .io_addr(io_addr), .io_size(io_size), .io_hit(io_hit), .io_offset(io_offset));

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(bit v, logic [15:0] a, logic [1:0] s);
    int nb;
    nb = (s == 2'd1) ? 2 : (s == 2'd2) ? 4 : 0;
    if (!v || !won_m || nb == 0) return 0;
    if (a[15:6] != wtag_m) return 0;
    if (int'(a[5:0]) + nb > 64) return 0;
    return 1;
  endfunction

  task automatic cfg_write(logic [5:0] idx, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_addr = idx; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
    if (idx == 6'h10) begin
      for (int b = 0; b < 4; b++) if (be[b]) base_m[8*b +: 8] = d[8*b +: 8];
      base_m[0] = 1'b1;
    end else if (idx == 6'h20 && be[0]) begin
      en_m = d[7:0]; won_m = d[0]; wtag_m = base_m[15:6];
    end
  endtask

  task automatic cfg_read(string req, logic [5:0] idx, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = idx;
    #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic sweep(string req, bit v, logic [15:0] lo, int n);
    io_valid = v;
    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < 4; s++) begin
        bit eh;
        io_addr = lo + 16'(i); io_size = 2'(s);
        #1;
        eh = exp_hit(v, io_addr, io_size);
        chk({req, " hit"}, {31'b0, io_hit}, {31'b0, eh});
        chk({req, " offset"}, {26'b0, io_offset}, eh ? {26'b0, io_addr[5:0]} : 32'h0);
      end
    end
    io_valid = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cfg_read("R1 base", 6'h10, 32'h1);
    cfg_read("R1 enable", 6'h20, 32'h0);
    sweep("R1", 1, 16'h0000, 80);
    // R2 base writes
    cfg_write(6'h10, 4'hF, 32'hFFFF_FFFE);
    cfg_read("R2 base all ones", 6'h10, 32'hFFFF_FFFF);
    cfg_write(6'h10, 4'hF, 32'h0000_B000);
    cfg_read("R2 base B000", 6'h10, 32'h0000_B001);
    sweep("R4 not yet enabled", 1, 16'hAFC0, 192);
    // R3 enable, R6 R7 R8 decode
    cfg_write(6'h20, 4'h1, 32'h1);
    cfg_read("R3 enable", 6'h20, 32'h1);
    sweep("R6 R7 R8 window B000", 1, 16'hAFC0, 192);
    // R4 base moves without enable write, R10 low bits ignored
    cfg_write(6'h10, 4'h3, 32'h0000_C03F);
    cfg_read("R2 base C03F", 6'h10, 32'h0000_C03F);
    sweep("R4 old window kept", 1, 16'hAFC0, 192);
    sweep("R4 new window inactive", 1, 16'hC000, 64);
    // R4 timing: new window only after the edge that takes the write
    @(negedge clk);
    cfg_wr = 1; cfg_addr = 6'h20; cfg_be = 4'h1; cfg_wdata = 32'h1;
    io_valid = 1; io_addr = 16'hC004; io_size = 2'd1;
    #1 chk("R4 before edge", {31'b0, io_hit}, 32'h0);
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
    en_m = 8'h1; won_m = 1; wtag_m = base_m[15:6];
    #1 chk("R4 after edge", {31'b0, io_hit}, 32'h1);
    io_valid = 0;
    sweep("R10 window C000", 1, 16'hBFC0, 192);
    // R2 partial byte enables, R10 upper bits ignored
    cfg_write(6'h10, 4'h2, 32'h0000_5500);
    cfg_read("R2 byte lane 1", 6'h10, 32'h0000_553F);
    cfg_write(6'h10, 4'hC, 32'hABCD_0000);
    cfg_read("R2 upper lanes", 6'h10, 32'hABCD_553F);
    cfg_write(6'h20, 4'h1, 32'h1);
    sweep("R10 window 5500", 1, 16'h54C0, 192);
    // R5 disable
    cfg_write(6'h20, 4'h1, 32'hA6);
    cfg_read("R3 enable A6", 6'h20, 32'hA6);
    sweep("R5 disabled", 1, 16'h54C0, 192);
    // R3 unmapped dword and upper bytes
    cfg_write(6'h03, 4'hF, 32'h1234_5671);
    cfg_read("R3 unmapped read", 6'h03, 32'h0);
    cfg_read("R3 base untouched", 6'h10, 32'hABCD_553F);
    sweep("R3 unmapped no window", 1, 16'h5500, 64);
    cfg_write(6'h20, 4'hE, 32'hFFFF_FF01);
    cfg_read("R3 lane0 only", 6'h20, 32'hA6);
    sweep("R3 no lane0 no enable", 1, 16'h5500, 64);
    cfg_write(6'h20, 4'hF, 32'hFFFF_FFFF);
    cfg_read("R3 upper bytes zero", 6'h20, 32'hFF);
    sweep("R6 re-enabled", 1, 16'h5500, 64);
    // R9 idle
    sweep("R9 valid low", 0, 16'h5500, 64);
    finish_run();
  end
endmodule